// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers eight active-high interrupt request lines from peripherals and presents a single interrupt request to a CPU that has only one interrupt input. Each line is latched on its rising edge unless that line is masked. Latched requests compete by fixed priority, with line 0 the most urgent, and they are also checked against the levels the CPU is already servicing. The block raises its request output only when a waiting request outranks every level currently in service.

The CPU answers with a two-cycle acknowledge. On the first cycle the winning line moves from pending to in service. On the second cycle the block drives an 8-bit type code, a fixed base plus the line number, onto its vector bus together with an output enable. A two-address register port lets software read and write the mask at offset 1. At offset 0 it accepts a non-specific end-of-interrupt command, which releases the most urgent level in service.

Top module: `prio_vic`

## Requirements
- R1: After reset the INT output is low, the mask reads 0x00 (every line enabled), the vector enable is low, and nothing is pending or in service.
- R2: A line is latched as pending on a 0-to-1 transition only. A line held high makes one request. Further edges on a line whose request is still pending are absorbed, not counted.
- R3: A 1 in mask bit n stops an edge on line n from being latched. A request latched before its line was masked is held off while the mask bit is set, and it becomes visible again once the bit is cleared.
- R4: INT is high exactly when some unmasked pending line has a strictly lower index than every line in service. Pending lines at the same or a higher index than the lowest in-service index are held off.
- R5: On the first acknowledge cycle the lowest-indexed eligible pending line is placed in service, and the vector enable stays low.
- R6: On the second acknowledge cycle the vector enable is high and the vector bus carries 8 + n, where n is the granted line (line 3 gives 0x0B). The pending bit of line n is cleared.
- R7: When several lines are pending at once, the lowest index is granted first.
- R8: Writing 0x20 to offset 0 clears the lowest-indexed in-service bit only. With nothing in service it has no effect.
- R9: Writing any byte other than 0x20 to offset 0 leaves the in-service state unchanged.
- R10: Writes to offset 1 load the 8-bit mask, and reads at offset 1 return it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 8 | Request lines, bit n is line n |
| addr_i | input | 1 | Register offset: 0 command, 1 mask |
| wr_i | input | 1 | Register write strobe, one cycle per write |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Read data: the mask at offset 1, zero at offset 0 |
| inta_i | input | 1 | Acknowledge strobe, high for one clock per acknowledge cycle |
| int_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 8 | Interrupt type code |
| vec_oe_o | output | 1 | Vector bus enable, high on the second acknowledge cycle |

## Verification
The bench sweeps every line alone and every pair of lines raised together. A design with a reversed or off-by-one priority encoder would return the wrong type code or grant the less urgent line first. Nested service gets its own tests: a same-level re-request while that level is in service must stay silent, a more urgent one must break through, and an end-of-interrupt must release only the innermost level. A controller that compared with "or equal", or that cleared the whole in-service set, would raise INT at the wrong moment. Masking is tried both before and after a request is latched, along with held-high lines, repeated edges, empty end-of-interrupts and non-EOI command bytes. Any of these would leave a spurious request behind in a design that counted edges or latched masked lines.

// File: rtl/prio_vic.sv
module prio_vic #(
  parameter logic [7:0] VEC_BASE = 8'h08,
  parameter logic [7:0] EOI_CMD  = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] irq_i,
  input  logic       addr_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       inta_i,
  output logic       int_o,
  output logic [7:0] vec_o,
  output logic       vec_oe_o
);

  localparam logic [3:0] NONE = 4'd8;

  function automatic logic [3:0] top_of(input logic [7:0] v);
    logic [3:0] r;
    r = NONE;
    for (int k = 7; k >= 0; k--)
      if (v[k]) r = 4'(k);
    return r;
  endfunction

  function automatic logic [7:0] onehot(input logic [3:0] idx);
    return (idx == NONE) ? 8'h00 : (8'h01 << idx[2:0]);
  endfunction

  logic [7:0] irq_q, irr, isr, imr;
  logic       ack2, ack_ok;
  logic [2:0] ack_lvl;

  logic [7:0] rise, eff, ack_set, ack_clr, eoi_clr;
  logic [3:0] pend_top, svc_top;
  logic       eligible, ack1_go, ack2_go, eoi;

  assign rise     = irq_i & ~irq_q;
  assign eff      = irr & ~imr;
  assign pend_top = top_of(eff);
  assign svc_top  = top_of(isr);
  assign eligible = pend_top < svc_top;
  assign int_o    = eligible;

  assign ack1_go  = inta_i & ~ack2;
  assign ack2_go  = inta_i & ack2;
  assign ack_set  = (ack1_go && eligible) ? onehot(pend_top) : 8'h00;
  assign ack_clr  = (ack2_go && ack_ok) ? (8'h01 << ack_lvl) : 8'h00;

  assign eoi      = wr_i & ~addr_i & (wdata_i == EOI_CMD);
  assign eoi_clr  = eoi ? onehot(svc_top) : 8'h00;

  assign vec_oe_o = ack2_go;
  assign vec_o    = VEC_BASE + {5'd0, ack_lvl};
  assign rdata_o  = addr_i ? imr : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q   <= 8'h00;
      irr     <= 8'h00;
      isr     <= 8'h00;
      imr     <= 8'h00;
      ack2    <= 1'b0;
      ack_ok  <= 1'b0;
      ack_lvl <= 3'd7;
    end else begin
      irq_q <= irq_i;
      irr   <= (irr & ~ack_clr) | (rise & ~imr);
      isr   <= (isr & ~eoi_clr) | ack_set;
      if (wr_i && addr_i) imr <= wdata_i;
      if (ack1_go) begin
        ack2    <= 1'b1;
        ack_ok  <= eligible;
        ack_lvl <= eligible ? pend_top[2:0] : 3'd7;
      end else if (ack2_go) begin
        ack2 <= 1'b0;
      end
    end
  end

  p_mask_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irr & ~$past(irr) & $past(imr)) == 8'h00));

  p_isr_set_by_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((isr & ~$past(isr)) != 8'h00) |-> $past(inta_i));

  p_one_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(isr & ~$past(isr)) <= 1));

  p_eoi_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !addr_i) |=> ($countones($past(isr) & ~isr) <= 1));

  p_vec_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe_o |-> (vec_o >= VEC_BASE && vec_o <= VEC_BASE + 8'd7));

endmodule

// File: tb/tb_prio_vic.sv
module tb_prio_vic;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_i;
  logic       addr_i, wr_i, inta_i;
  logic [7:0] wdata_i;
  logic [7:0] rdata_o, vec_o;
  logic       int_o, vec_oe_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  prio_vic dut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .addr_i(addr_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .inta_i(inta_i), .int_o(int_o),
    .vec_o(vec_o), .vec_oe_o(vec_oe_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse(input logic [7:0] lines);
    irq_i = lines; step();
    irq_i = 8'h00; step();
  endtask

  task automatic wr(input bit a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1; step();
    wr_i = 1'b0; addr_i = 1'b0;
  endtask

  task automatic ack(input int exp_line, input string req);
    inta_i = 1'b1; #1;
    check(vec_oe_o == 1'b0, "R5 enable low on first cycle", vec_oe_o, 0);
    step();
    check(vec_oe_o == 1'b1, "R6 enable high on second cycle", vec_oe_o, 1);
    check(vec_o == 8'(8 + exp_line), req, vec_o, 8 + exp_line);
    step();
    inta_i = 1'b0;
  endtask

  task automatic eoi();
    wr(1'b0, 8'h20);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_i = 8'h00; addr_i = 1'b0; wr_i = 1'b0; wdata_i = 8'h00; inta_i = 1'b0;
    repeat (3) step();
    rst_n = 1'b1; step();

    addr_i = 1'b1; #1;
    check(int_o == 1'b0, "R1 int after reset", int_o, 0);
    check(rdata_o == 8'h00, "R1 mask after reset", rdata_o, 0);
    check(vec_oe_o == 1'b0, "R1 enable after reset", vec_oe_o, 0);
    addr_i = 1'b0;

    // R8 empty EOI has no effect
    eoi(); #1;
    check(int_o == 1'b0, "R8 empty EOI", int_o, 0);

    // single-line sweep
    for (int n = 0; n < 8; n++) begin
      pulse(8'h01 << n); #1;
      check(int_o == 1'b1, "R2 edge latched", int_o, 1);
      ack(n, "R6 single-line type");
      #1 check(int_o == 1'b0, "R4 held off by own level", int_o, 0);
      eoi(); #1;
      check(int_o == 1'b0, "R6 pending cleared after ack", int_o, 0);
    end

    // pair sweep: simultaneous edges
    for (int i = 0; i < 8; i++) begin
      for (int j = i + 1; j < 8; j++) begin
        pulse((8'h01 << i) | (8'h01 << j)); #1;
        check(int_o == 1'b1, "R4 pair raises int", int_o, 1);
        ack(i, "R7 lower index first");
        #1 check(int_o == 1'b0, "R4 lower level held off", int_o, 0);
        eoi(); #1;
        check(int_o == 1'b1, "R8 EOI releases lower level", int_o, 1);
        ack(j, "R7 second grant");
        eoi(); #1;
        check(int_o == 1'b0, "R6 all cleared", int_o, 0);
      end
    end

    // nesting
    pulse(8'h20); ack(5, "R6 nest outer");
    pulse(8'h20); #1;
    check(int_o == 1'b0, "R4 same level held off", int_o, 0);
    pulse(8'h04); #1;
    check(int_o == 1'b1, "R4 higher level breaks through", int_o, 1);
    ack(2, "R6 nest inner");
    eoi(); #1;
    check(int_o == 1'b0, "R8 EOI clears only inner level", int_o, 0);
    eoi(); #1;
    check(int_o == 1'b1, "R8 second EOI frees level 5", int_o, 1);
    ack(5, "R6 re-request of level 5");
    eoi(); #1;
    check(int_o == 1'b0, "R2 one request only", int_o, 0);

    // masking before the edge
    for (int n = 0; n < 8; n++) begin
      wr(1'b1, 8'h01 << n);
      addr_i = 1'b1; #1;
      check(rdata_o == 8'(8'h01 << n), "R10 mask read back", rdata_o, 8'h01 << n);
      addr_i = 1'b0;
      pulse(8'h01 << n); #1;
      check(int_o == 1'b0, "R3 masked edge ignored", int_o, 0);
      wr(1'b1, 8'h00); #1;
      check(int_o == 1'b0, "R3 masked edge not latched", int_o, 0);
    end

    // masking after the edge
    pulse(8'h08);
    wr(1'b1, 8'h08); #1;
    check(int_o == 1'b0, "R3 latched request held off", int_o, 0);
    wr(1'b1, 8'h00); #1;
    check(int_o == 1'b1, "R3 unmask restores request", int_o, 1);
    ack(3, "R6 line 3 gives 0x0B");
    eoi();

    // held-high line and repeated edges
    irq_i = 8'h10; repeat (6) step();
    ack(4, "R2 held line grant");
    eoi(); #1;
    check(int_o == 1'b0, "R2 held line one request", int_o, 0);
    irq_i = 8'h00; step();
    pulse(8'h02); pulse(8'h02);
    ack(1, "R2 repeated edge grant");
    eoi(); #1;
    check(int_o == 1'b0, "R2 repeated edge absorbed", int_o, 0);

    // non-EOI command byte
    pulse(8'h40); ack(6, "R6 line 6");
    wr(1'b0, 8'h21);
    pulse(8'h80); #1;
    check(int_o == 1'b0, "R9 other byte keeps level 6", int_o, 0);
    eoi(); #1;
    check(int_o == 1'b1, "R8 EOI then line 7 visible", int_o, 1);
    ack(7, "R6 line 7");
    eoi(); #1;
    check(int_o == 1'b0, "R8 final idle", int_o, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule